// File: doc/BRIEF.md
# Sticky Status Summary with Latched Alert

This block keeps the fault and warning status of a multi-channel power controller. Fault sources send one-cycle event pulses, one bit for each condition. Each pulse sets a sticky bit, and the bit stays set after the condition has gone. There are four kinds of detailed register:

- an output-voltage register for each channel;
- an output-current register for each channel;
- one shared input register;
- one shared temperature register.

The bus engine sits outside this block. It reads the registers and clears bits through a write-one-to-clear port. It also forwards three command pulses: a global clear, a restore-settings command and a reset command.

For each channel the block builds a 16-bit summary word, and the low byte of that word is the summary byte. It also drives an active-low alert output, which is low whenever any sticky bit is set.

Two small state machines control the alert and the channels:

- **Alert machine.** It has two states, QUIET and RAISED. The transition QUIET→RAISED happens when any sticky bit is set. The transition RAISED→QUIET happens when every sticky bit is clear. The alert output is low exactly in RAISED.
- **Channel machine.** There is one per channel, with two states, RUN and OFF. The transition RUN→OFF (commanded off) happens when the channel's off request is high. It clears that channel's voltage and current registers in the same cycle. The transition OFF→RUN (released) happens when the off request falls.

Top module: `stat_alert_top`

## Requirements
- R1: An event pulse on any bit sets the matching status bit at the next clock edge, and the bit stays set after the pulse ends until some clear acts on it.
- R2: When a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R3: A write with `wr_en` high clears each bit of the selected register whose `wr_data` bit is 1 and leaves every bit written 0 unchanged. Register select codes:
  - 2c is the voltage register of channel c;
  - 2c+1 is the current register of channel c;
  - 2·NCH is the input register;
  - 2·NCH+1 is the temperature register.
- R4: A `clr_all` pulse zeroes every status register at the next edge.
- R5: A `cmd_restore` or `cmd_reset` pulse zeroes every status register at the next edge.
- R6: The RUN→OFF transition of a channel clears that channel's voltage and current registers only. While the channel stays OFF, new events set those bits again and they are not re-cleared.
- R7: `alert_n` goes low one clock after any status bit becomes set, and stays low while any bit is set.
- R8: `alert_n` returns high one clock after the last set bit is cleared.
- R9: Upper summary bits for channel c:
  - bit 15 is high when the voltage register is nonzero;
  - bit 14 is high when the current register is nonzero;
  - bit 13 is high when the input register is nonzero;
  - bit 12 is high when the temperature register is nonzero;
  - bits 11..8 are 0.
- R10: Summary bits 7..1 for channel c:
  - bit 7 is the voltage register's top bit;
  - bit 6 is the channel's OFF state (`ch_off`);
  - bit 5 is the current register's top bit;
  - bit 4 is the input register's top bit;
  - bit 3 is the temperature register's top bit;
  - bits 2..1 are 0.
  
  `sum_byte` equals `sum_word[7:0]`.
- R11: Summary bit 0 (catch-all) is high exactly when any of summary bits 15..12 is high.
- R12: After reset:
  - all registers are zero;
  - `alert_n` is high;
  - every channel is in RUN (`ch_off` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_vout | input | NCH*W | Voltage event pulses, channel c at bits c*W |
| ev_iout | input | NCH*W | Current event pulses, channel c at bits c*W |
| ev_in | input | W | Input event pulses |
| ev_temp | input | W | Temperature event pulses |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_sel | input | SEL_W | Register select code |
| wr_data | input | W | Write data, ones clear |
| clr_all | input | 1 | Global clear pulse |
| cmd_restore | input | 1 | Restore-settings command pulse |
| cmd_reset | input | 1 | Reset command pulse |
| off_req | input | NCH | Per-channel commanded-off level |
| st_vout | output | NCH*W | Voltage status registers |
| st_iout | output | NCH*W | Current status registers |
| st_in | output | W | Input status register |
| st_temp | output | W | Temperature status register |
| ch_off | output | NCH | Channel in OFF state |
| sum_word | output | NCH*16 | Summary word per channel |
| sum_byte | output | NCH*8 | Summary byte per channel |
| alert_n | output | 1 | Active-low alert |

## Verification
The assertions check the following on every cycle:
- a set always survives a same-cycle clear;
- bits with no clear acting on them keep their value;
- full clears and the off transition empty the targeted registers;
- the alert follows the OR of all sticky bits, one cycle late.

The summary bit layout can only be shown by the bench's sweeps:
- every register and bit position is pulsed, then written zero, then written one;
- the catch-all bit is checked in each of those states.

The interplay of a held off request with new events is also covered only by bench scenarios.

// File: rtl/stat_pkg.sv
package stat_pkg;

    typedef enum logic [0:0] {
        CH_RUN = 1'b0,
        CH_OFF = 1'b1
    } ch_state_e;

    typedef enum logic [0:0] {
        AL_QUIET  = 1'b0,
        AL_RAISED = 1'b1
    } alert_state_e;

    localparam int SUM_W       = 16;
    localparam int SB_CATCH    = 0;
    localparam int SB_TEMP_TOP = 3;
    localparam int SB_IN_TOP   = 4;
    localparam int SB_IOUT_TOP = 5;
    localparam int SB_OFF      = 6;
    localparam int SB_VOUT_TOP = 7;
    localparam int SB_TEMP_ANY = 12;
    localparam int SB_IN_ANY   = 13;
    localparam int SB_IOUT_ANY = 14;
    localparam int SB_VOUT_ANY = 15;

endpackage

// File: rtl/stat_sticky.sv
module stat_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // Set has priority over clear on each bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_i) | set_i;
        end
    end

    // R2 / R1: a pulsed bit is present after the edge, whatever clears arrived.
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R1: with no clear, nothing already set is lost.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));

    // R4: a full clear with no set empties the register.
    p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((&clr_i) && (set_i == '0)) |=> (q_o == '0));

endmodule

// File: rtl/stat_chan_seq.sv
module stat_chan_seq
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic off_req_i,
    output logic clr_o,
    output logic off_o
);

    ch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_RUN: if (off_req_i)  state_d = CH_OFF;
            CH_OFF: if (!off_req_i) state_d = CH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        clr_o = 1'b0;
        off_o = 1'b0;
        unique case (state_q)
            CH_RUN: clr_o = off_req_i;
            CH_OFF: off_o = 1'b1;
        endcase
    end

    // R10: the OFF flag follows a held request one cycle later.
    p_off_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
        off_req_i |=> off_o);

    // R6: the channel clear fires once per RUN->OFF transition.
    p_single_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);

endmodule

// File: rtl/stat_alert_fsm.sv
module stat_alert_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic alert_n_o
);

    alert_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_QUIET:  if (any_i)  state_d = AL_RAISED;
            AL_RAISED: if (!any_i) state_d = AL_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AL_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            AL_QUIET:  alert_n_o = 1'b1;
            AL_RAISED: alert_n_o = 1'b0;
        endcase
    end

    p_alert_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_i |=> !alert_n_o);

    p_alert_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_i |=> alert_n_o);

endmodule

// File: rtl/stat_summary.sv
module stat_summary
    import stat_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     vout_i,
    input  logic [W-1:0]     iout_i,
    input  logic [W-1:0]     in_i,
    input  logic [W-1:0]     temp_i,
    input  logic             off_i,
    output logic [SUM_W-1:0] word_o
);

    localparam int TOPB = W - 1;

    always_comb begin
        word_o              = '0;
        word_o[SB_VOUT_ANY] = |vout_i;
        word_o[SB_IOUT_ANY] = |iout_i;
        word_o[SB_IN_ANY]   = |in_i;
        word_o[SB_TEMP_ANY] = |temp_i;
        word_o[SB_VOUT_TOP] = vout_i[TOPB];
        word_o[SB_OFF]      = off_i;
        word_o[SB_IOUT_TOP] = iout_i[TOPB];
        word_o[SB_IN_TOP]   = in_i[TOPB];
        word_o[SB_TEMP_TOP] = temp_i[TOPB];
        word_o[SB_CATCH]    = |{vout_i, iout_i, in_i, temp_i};
    end

endmodule

// File: rtl/stat_alert_top.sv
module stat_alert_top
    import stat_pkg::*;
#(
    parameter  int NCH   = 2,
    parameter  int W     = 8,
    localparam int NREG  = 2 * NCH + 2,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH*W-1:0]   ev_vout,
    input  logic [NCH*W-1:0]   ev_iout,
    input  logic [W-1:0]       ev_in,
    input  logic [W-1:0]       ev_temp,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [W-1:0]       wr_data,
    input  logic               clr_all,
    input  logic               cmd_restore,
    input  logic               cmd_reset,
    input  logic [NCH-1:0]     off_req,
    output logic [NCH*W-1:0]   st_vout,
    output logic [NCH*W-1:0]   st_iout,
    output logic [W-1:0]       st_in,
    output logic [W-1:0]       st_temp,
    output logic [NCH-1:0]     ch_off,
    output logic [NCH*16-1:0]  sum_word,
    output logic [NCH*8-1:0]   sum_byte,
    output logic               alert_n
);

    localparam int IDX_IN   = 2 * NCH;
    localparam int IDX_TEMP = 2 * NCH + 1;

    logic [W-1:0]   set_v [NREG];
    logic [W-1:0]   clr_v [NREG];
    logic [W-1:0]   q_v   [NREG];
    logic [NCH-1:0] ch_clr;
    logic           glob_clr;
    logic           any_set;

    assign glob_clr = clr_all | cmd_restore | cmd_reset;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        stat_chan_seq u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .off_req_i (off_req[c]),
            .clr_o     (ch_clr[c]),
            .off_o     (ch_off[c])
        );

        assign st_vout[c*W +: W] = q_v[2*c];
        assign st_iout[c*W +: W] = q_v[2*c+1];

        stat_summary #(.W(W)) u_sum (
            .vout_i (q_v[2*c]),
            .iout_i (q_v[2*c+1]),
            .in_i   (q_v[IDX_IN]),
            .temp_i (q_v[IDX_TEMP]),
            .off_i  (ch_off[c]),
            .word_o (sum_word[c*16 +: 16])
        );

        assign sum_byte[c*8 +: 8] = sum_word[c*16 +: 8];

        // R6: the off transition empties this channel's registers.
        p_chan_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_clr[c] && (ev_vout[c*W +: W] == '0) && (ev_iout[c*W +: W] == '0))
            |=> ((st_vout[c*W +: W] == '0) && (st_iout[c*W +: W] == '0)));
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [W-1:0] wr_mask;
        logic [W-1:0] own_mask;

        assign wr_mask = (wr_en && (wr_sel == SEL_W'(r))) ? wr_data : '0;

        if (r < 2 * NCH) begin : g_owned
            assign own_mask = ch_clr[r/2] ? '1 : '0;
            if ((r % 2) == 0) begin : g_v
                assign set_v[r] = ev_vout[(r/2)*W +: W];
            end else begin : g_i
                assign set_v[r] = ev_iout[(r/2)*W +: W];
            end
        end else if (r == IDX_IN) begin : g_in
            assign own_mask = '0;
            assign set_v[r] = ev_in;
        end else begin : g_temp
            assign own_mask = '0;
            assign set_v[r] = ev_temp;
        end

        assign clr_v[r] = wr_mask | own_mask | (glob_clr ? '1 : '0);

        stat_sticky #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[r]),
            .clr_i (clr_v[r]),
            .q_o   (q_v[r])
        );
    end

    assign st_in   = q_v[IDX_IN];
    assign st_temp = q_v[IDX_TEMP];

    always_comb begin
        any_set = 1'b0;
        for (int r = 0; r < NREG; r++) begin
            any_set = any_set | (|q_v[r]);
        end
    end

    stat_alert_fsm u_alert (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (any_set),
        .alert_n_o (alert_n)
    );

    // R5: reset-type commands with no events leave nothing set.
    p_cmd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_restore || cmd_reset) && (ev_vout == '0) && (ev_iout == '0)
         && (ev_in == '0) && (ev_temp == '0))
        |=> ((st_vout == '0) && (st_iout == '0) && (st_in == '0) && (st_temp == '0)));

endmodule

// File: tb/sim_stat_alert_top.sv
module sim_stat_alert_top;

    localparam int NCH = 2;
    localparam int W   = 8;
    localparam int NR  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       ev [NR];
    logic             wr_en = 1'b0;
    logic [2:0]       wr_sel = '0;
    logic [7:0]       wr_data = '0;
    logic             clr_all = 1'b0;
    logic             cmd_restore = 1'b0;
    logic             cmd_reset = 1'b0;
    logic [1:0]       off_req = '0;
    logic [15:0]      st_vout, st_iout;
    logic [7:0]       st_in, st_temp;
    logic [1:0]       ch_off;
    logic [31:0]      sum_word;
    logic [15:0]      sum_byte;
    logic             alert_n;

    logic [7:0]       exp_r [NR];
    logic [1:0]       exp_off;
    logic             exp_alert_n;
    int               n_tests = 0;
    int               n_fail  = 0;

    always #10 clk = ~clk;

    stat_alert_top #(.NCH(NCH), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_vout({ev[2], ev[0]}), .ev_iout({ev[3], ev[1]}),
        .ev_in(ev[4]), .ev_temp(ev[5]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clr_all(clr_all), .cmd_restore(cmd_restore), .cmd_reset(cmd_reset),
        .off_req(off_req),
        .st_vout(st_vout), .st_iout(st_iout), .st_in(st_in), .st_temp(st_temp),
        .ch_off(ch_off), .sum_word(sum_word), .sum_byte(sum_byte), .alert_n(alert_n)
    );

    function automatic logic [7:0] act_reg(int r);
        case (r)
            0: return st_vout[7:0];
            1: return st_iout[7:0];
            2: return st_vout[15:8];
            3: return st_iout[15:8];
            4: return st_in;
            default: return st_temp;
        endcase
    endfunction

    function automatic logic [15:0] exp_word(int c);
        logic [15:0] w;
        w = '0;
        w[15] = exp_r[2*c] != 0;
        w[14] = exp_r[2*c+1] != 0;
        w[13] = exp_r[4] != 0;
        w[12] = exp_r[5] != 0;
        w[7]  = exp_r[2*c][7];
        w[6]  = exp_off[c];
        w[5]  = exp_r[2*c+1][7];
        w[4]  = exp_r[4][7];
        w[3]  = exp_r[5][7];
        w[0]  = w[15] | w[14] | w[13] | w[12];
        return w;
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic check_all(string rq);
        for (int r = 0; r < NR; r++) chk(rq, $sformatf("reg %0d", r), 32'(act_reg(r)), 32'(exp_r[r]));
        chk("R7 R8", "alert_n", 32'(alert_n), 32'(exp_alert_n));
        chk("R6 R10", "ch_off", 32'(ch_off), 32'(exp_off));
        for (int c = 0; c < NCH; c++) begin
            chk("R9 R10 R11", $sformatf("sum_word ch%0d", c), 32'(sum_word[c*16 +: 16]), 32'(exp_word(c)));
            chk("R10", $sformatf("sum_byte ch%0d", c), 32'(sum_byte[c*8 +: 8]), 32'(exp_word(c) & 16'hff));
        end
    endtask

    // Apply the inputs driven now across one clock edge and update the model.
    task automatic tick();
        logic [7:0] nxt [NR];
        logic [7:0] clr;
        logic       any;
        any = 1'b0;
        for (int r = 0; r < NR; r++) begin
            any = any | (exp_r[r] != 0);
            clr = '0;
            if (wr_en && wr_sel == 3'(r)) clr = clr | wr_data;
            if (clr_all || cmd_restore || cmd_reset) clr = 8'hff;
            if (r < 4 && off_req[r/2] && !exp_off[r/2]) clr = 8'hff;
            nxt[r] = (exp_r[r] & ~clr) | ev[r];
        end
        @(negedge clk);
        exp_alert_n = ~any;
        for (int r = 0; r < NR; r++) exp_r[r] = nxt[r];
        exp_off = off_req;
        for (int r = 0; r < NR; r++) ev[r] = '0;
        wr_en = 0; wr_data = '0; clr_all = 0; cmd_restore = 0; cmd_reset = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin ev[r] = '0; exp_r[r] = '0; end
        exp_off = '0; exp_alert_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R12");

        // Sweep every register and bit: set, hold, write zero, write one.
        for (int r = 0; r < NR; r++) begin
            for (int b = 0; b < 8; b++) begin
                ev[r] = 8'(1 << b); tick(); check_all("R1");
                tick(); check_all("R1 R7");
                wr_en = 1; wr_sel = 3'(r); wr_data = ~8'(1 << b); tick(); check_all("R3");
                wr_en = 1; wr_sel = 3'(r); wr_data = 8'(1 << b); tick(); check_all("R3");
                tick(); check_all("R8");
            end
        end

        // R2: set and write-one-clear on the same bit in one cycle.
        ev[4] = 8'h81; tick();
        ev[4] = 8'h01; wr_en = 1; wr_sel = 3'd4; wr_data = 8'h81; tick(); check_all("R2");
        // R2: set with a global clear in the same cycle.
        ev[1] = 8'h10; clr_all = 1; tick(); check_all("R2");
        tick(); check_all("R2");

        // R4: global clear of several registers.
        ev[0] = 8'hf0; ev[3] = 8'h0f; ev[5] = 8'h80; tick(); check_all("R4");
        clr_all = 1; tick(); check_all("R4");
        tick(); check_all("R4");

        // R5: restore command, then reset command.
        ev[2] = 8'h33; ev[4] = 8'h44; tick();
        cmd_restore = 1; tick(); check_all("R5");
        ev[1] = 8'h80; ev[5] = 8'h01; tick();
        cmd_reset = 1; tick(); check_all("R5");
        tick(); check_all("R5");

        // R6: channel 1 commanded off clears only its own registers.
        ev[0] = 8'h02; ev[1] = 8'h04; ev[2] = 8'h88; ev[3] = 8'h11; ev[4] = 8'h20; tick();
        off_req = 2'b10; tick(); check_all("R6");
        ev[2] = 8'h01; tick(); check_all("R6");
        tick(); check_all("R6");
        off_req = 2'b00; tick(); check_all("R6");
        off_req = 2'b01; tick(); check_all("R6");
        off_req = 2'b00; tick(); check_all("R6");
        clr_all = 1; tick(); check_all("R8");
        tick(); check_all("R8 R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule